// File: doc/BRIEF.md
# Clock-Ready Interrupt Flag Register

This block holds the pending-interrupt flags of a clock controller. Seven sticky flags share one read-only status word. Five of them report that an oscillator has become stable. The other two report that a failure detector has seen an external oscillator stop. The stable and failure inputs may come from foreign clock domains. Each one passes through a synchronizer and then a rising-edge detector before it can set its flag.

A ready flag is armed only while its ready-interrupt enable is high. The two high-speed internal oscillators have one more condition: the oscillator must have been switched on by software through its ON bit. When a peripheral clock request alone brings one of these oscillators up, its flag stays 0.

Software clears a flag by writing 1 to the matching bit of a separate clear register. That clear register always reads back as zero. A single interrupt line carries the registered OR of all flags.

Top module: `clkirq_flags`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge), all flags, the flag word and irq_o are 0.
- R2: The flag word uses these bit positions. Bit 0 is the low-speed internal ready flag and bit 1 the low-speed external ready flag. Bit 2 is the primary high-speed internal ready flag and bit 3 the auxiliary high-speed internal ready flag. Bit 4 is the high-speed external ready flag. Bit 5 is the high-speed external failure flag and bit 6 the low-speed external failure flag. Bits 7 and above always read 0. Stable input k drives bit k, and failure input j drives bit 5+j.
- R3: A 0-to-1 step on a stable input sets its ready flag on the third rising clock edge after the step, when that source's ready-interrupt enable is 1. With the enable at 0, the flag stays 0.
- R4: Bits 2 and 3 are set only when sw_on_i[0] or sw_on_i[1] respectively is 1. A peripheral clock request with the ON bit at 0 never sets them.
- R5: A 0-to-1 step on a failure input sets its failure flag on the third rising edge after the step, whatever the enables hold.
- R6: A flag is set only by a rising edge. A stable input that stays high does not set its flag again after the flag is cleared.
- R7: When clr_wr_i is high at a clock edge, each flag whose bit in clr_data_i is 1 is cleared. Bits of 0, bits above 6, and data presented while clr_wr_i is low have no effect.
- R8: If a set event and a clear of the same flag happen on the same edge, the flag ends up set.
- R9: irq_o equals the OR of the flag word as it stood one clock cycle earlier.
- R10: The clear-register read port clr_word_o always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_stable_i | input | 5 | Per-oscillator stable level, may be asynchronous |
| osc_fail_i | input | 2 | Failure detect for high-speed external [0] and low-speed external [1] oscillators |
| rdy_ie_i | input | 5 | Ready-interrupt enables, one per stable input |
| sw_on_i | input | 2 | Software ON bits of the primary [0] and auxiliary [1] high-speed internal oscillators |
| periph_req_i | input | 2 | Peripheral clock requests for the same two oscillators |
| clr_wr_i | input | 1 | Write strobe of the clear register |
| clr_data_i | input | DATA_W | Write data of the clear register, 1 clears |
| flag_word_o | output | DATA_W | Registered flag word |
| clr_word_o | output | DATA_W | Read-back of the clear register, always 0 |
| irq_o | output | 1 | Registered OR of all flags |

## Verification
The collision of a set and a clear on the same edge is the hardest case to reach from the ports. The set event only exists inside the block, two synchronizer stages after the input moves. The bench raises a stable input and counts two edges. It then holds the clear strobe so that it coincides with the edge that latches the flag, and checks that the flag survives. A sweep over every source, enable, ON bit and request combination covers the software-versus-peripheral gating of the two high-speed internal flags.

// File: rtl/clkirq_pkg.sv
package clkirq_pkg;
  localparam int NUM_RDY   = 5;
  localparam int NUM_FAIL  = 2;
  localparam int NUM_FLAGS = NUM_RDY + NUM_FAIL;
  localparam int NUM_SWCTL = 2;

  localparam int IDX_LSINT_RDY  = 0;
  localparam int IDX_LSEXT_RDY  = 1;
  localparam int IDX_HSINT_RDY  = 2;
  localparam int IDX_HSAUX_RDY  = 3;
  localparam int IDX_HSEXT_RDY  = 4;
  localparam int IDX_HSEXT_FAIL = 5;
  localparam int IDX_LSEXT_FAIL = 6;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/clkirq_sync.sv
module clkirq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkirq_rise.sv
module clkirq_rise #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R6
endmodule

// File: rtl/clkirq_flagbank.sv
module clkirq_flagbank #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_chk
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
      set_i[b] |=> q_o[b]); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (clr_i[b] && !set_i[b]) |=> !q_o[b]); // R7
  end
endmodule

// File: rtl/clkirq_flags.sv
module clkirq_flags
  import clkirq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RDY-1:0]   osc_stable_i,
  input  logic [NUM_FAIL-1:0]  osc_fail_i,
  input  logic [NUM_RDY-1:0]   rdy_ie_i,
  input  logic [NUM_SWCTL-1:0] sw_on_i,
  input  logic [NUM_SWCTL-1:0] periph_req_i,
  input  logic                 clr_wr_i,
  input  logic [DATA_W-1:0]    clr_data_i,
  output logic [DATA_W-1:0]    flag_word_o,
  output logic [DATA_W-1:0]    clr_word_o,
  output logic                 irq_o
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  flag_vec_t raw_in, sync_lvl, rise_ev, set_vec, clr_vec, flag_q;
  logic [NUM_RDY-1:0] set_rdy;
  logic               unused_hi;

  assign raw_in = {osc_fail_i, osc_stable_i};

  clkirq_sync #(.WIDTH(NUM_FLAGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(sync_lvl)
  );

  clkirq_rise #(.WIDTH(NUM_FLAGS)) u_rise (
    .clk(clk), .rst(rst), .lvl_i(sync_lvl), .rise_o(rise_ev)
  );

  for (genvar g = 0; g < NUM_RDY; g++) begin : g_rdy
    if (g == IDX_HSINT_RDY) begin : g_sw0
      assign set_rdy[g] = rise_ev[g] & rdy_ie_i[g] & sw_on_i[0];
    end else if (g == IDX_HSAUX_RDY) begin : g_sw1
      assign set_rdy[g] = rise_ev[g] & rdy_ie_i[g] & sw_on_i[1];
    end else begin : g_plain
      assign set_rdy[g] = rise_ev[g] & rdy_ie_i[g];
    end
  end

  assign set_vec   = {rise_ev[NUM_FLAGS-1:NUM_RDY], set_rdy};
  assign clr_vec   = clr_wr_i ? clr_data_i[NUM_FLAGS-1:0] : '0;
  assign unused_hi = ^clr_data_i[DATA_W-1:NUM_FLAGS];

  clkirq_flagbank #(.WIDTH(NUM_FLAGS)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec), .q_o(flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |flag_q;
  end

  assign flag_word_o = {{PAD_W{1'b0}}, flag_q};
  assign clr_word_o  = '0;

  for (genvar g = 0; g < NUM_RDY; g++) begin : g_ie_chk
    AST_RDY_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
      $rose(flag_q[g]) |-> $past(rdy_ie_i[g])); // R3
  end

  AST_HSINT_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[IDX_HSINT_RDY]) |-> $past(sw_on_i[0])); // R4
  AST_HSAUX_NEEDS_ON: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[IDX_HSAUX_RDY]) |-> $past(sw_on_i[1])); // R4
  AST_HSINT_REQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (periph_req_i[0] && !sw_on_i[0] && !flag_q[IDX_HSINT_RDY]) |=> !flag_q[IDX_HSINT_RDY]); // R4
  AST_HSAUX_REQ_SILENT: assert property (@(posedge clk) disable iff (rst)
    (periph_req_i[1] && !sw_on_i[1] && !flag_q[IDX_HSAUX_RDY]) |=> !flag_q[IDX_HSAUX_RDY]); // R4
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|flag_word_o))); // R9
endmodule

// File: tb/clkirq_flags_test.sv
`timescale 1ns/1ps
module clkirq_flags_test;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    stable = '0;
  logic [1:0]    fail = '0;
  logic [4:0]    ie = '0;
  logic [1:0]    swon = '0;
  logic [1:0]    preq = '0;
  logic          clr_wr = 1'b0;
  logic [DW-1:0] clr_data = '0;
  logic [DW-1:0] word, clrw;
  logic          irq;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clkirq_flags #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .osc_stable_i(stable), .osc_fail_i(fail),
    .rdy_ie_i(ie), .sw_on_i(swon), .periph_req_i(preq),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data),
    .flag_word_o(word), .clr_word_o(clrw), .irq_o(irq)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = '1;
    tick(1);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic quiesce();
    stable = '0; fail = '0;
    tick(4);
    clear_all();
    tick(2);
  endtask

  initial begin
    tick(3);
    check("R1 flag word in reset", word, '0);
    check("R1 irq in reset", {31'd0, irq}, '0);
    rst = 1'b0;
    tick(1);
    check("R1 flag word after reset", word, '0);

    // R3 / R4 sweep: every ready source against enable, ON bit, request
    for (int src = 0; src < 5; src++) begin
      for (int cfg = 0; cfg < 8; cfg++) begin
        logic [DW-1:0] exp;
        logic gate;
        quiesce();
        ie   = cfg[0] ? (5'd1 << src) : 5'd0;
        swon = cfg[1] ? 2'b11 : 2'b00;
        preq = cfg[2] ? 2'b11 : 2'b00;
        gate = cfg[0];
        if (src == 2 || src == 3) gate = gate & cfg[1];
        exp = gate ? (32'd1 << src) : 32'd0;
        stable[src] = 1'b1;
        tick(2);
        check("R3 no flag before third edge", word, '0);
        tick(1);
        if (src == 2 || src == 3) check("R4 high-speed internal gating", word, exp);
        else                      check("R3 ready flag", word, exp);
        tick(1);
        check("R9 irq follows flags", {31'd0, irq}, {31'd0, (exp != 0)});
      end
    end
    swon = '0; preq = '0;

    // R5 failure flags ignore enables
    for (int j = 0; j < 2; j++) begin
      for (int e = 0; e < 2; e++) begin
        quiesce();
        ie = e ? 5'h1f : 5'h00;
        fail[j] = 1'b1;
        tick(3);
        check("R5 failure flag", word, 32'd1 << (5 + j));
      end
    end

    // R6 steady stable level does not set again
    quiesce();
    ie = 5'h1f;
    stable[1] = 1'b1;
    tick(3);
    check("R6 first edge sets", word, 32'h2);
    clear_all();
    tick(5);
    check("R6 no re-set while level held", word, '0);

    // R7 / R2 / R10 selective clear
    quiesce();
    ie = 5'h1f; swon = 2'b11;
    stable = 5'h1f; fail = 2'b11;
    tick(3);
    check("R2 all seven flags", word, 32'h7f);
    check("R2 upper bits zero", {7'd0, word[DW-1:7]}, '0);
    clr_wr = 1'b1; clr_data = 32'h05;
    tick(1);
    clr_wr = 1'b0;
    check("R7 clear selected bits", word, 32'h7a);
    clr_wr = 1'b1; clr_data = 32'h0;
    tick(1);
    check("R7 zero write no effect", word, 32'h7a);
    clr_data = 32'hffffff80;
    tick(1);
    clr_wr = 1'b0;
    check("R7 upper bits no effect", word, 32'h7a);
    clr_data = '1;
    tick(1);
    check("R7 data without strobe no effect", word, 32'h7a);
    check("R10 clear register reads zero", clrw, '0);
    clear_all();
    check("R7 full clear", word, '0);
    check("R9 irq lags clear", {31'd0, irq}, 32'd1);
    tick(1);
    check("R9 irq drops", {31'd0, irq}, '0);
    swon = '0;

    // R8 set and clear on the same edge
    quiesce();
    ie = 5'h1f;
    stable[0] = 1'b1;
    tick(2);
    clr_wr = 1'b1; clr_data = '1;
    tick(1);
    clr_wr = 1'b0; clr_data = '0;
    check("R8 set wins over clear", word, 32'h1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule